// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the fixed fields of a 32-bit instruction word into the strobes that steer a single-cycle datapath. It reads the 6-bit opcode, the 6-bit function field and the ALU zero flag. From these it drives the destination select, the register write enable, the second-operand select, a 3-bit ALU operation code, the memory read and write strobes, the write-back source select and the next-PC select. It covers eight instructions: five register-to-register operations (add, sub, and, or, set-less-than), a word load, a word store and a branch-if-equal.

The block is purely combinational and has no state. The ALU operation is chosen in the same flat decode as the other strobes. There is no second-level ALU control stage. Any opcode or function code outside the supported set is reported on an illegal-instruction output. In that case every write and memory strobe is held low, so a bad instruction cannot change architectural state.

Top module: `insn_ctrl_decoder`

## Requirements
- R1: With opcode 000000 and a supported function code, the outputs are regDst=1, regWrite=1, aluSrc=0, memRead=0, memWrite=0, memToReg=0 and pcSrc=0.
- R2: For opcode 000000, the function code selects aluOp: 100000→010 (add), 100010→110 (sub), 100100→000 (and), 100101→001 (or), 101010→111 (slt).
- R3: Opcode 100011 (load) gives regDst=0, regWrite=1, aluSrc=1, aluOp=010, memRead=1, memWrite=0, memToReg=1 and pcSrc=0.
- R4: Opcode 101011 (store) gives regWrite=0, aluSrc=1, aluOp=010, memWrite=1 and memRead=0, with the don't-care outputs regDst and memToReg driven to 0.
- R5: Opcode 000100 (branch-if-equal) gives regWrite=0, aluSrc=0, aluOp=110, memRead=0, memWrite=0, regDst=0 and memToReg=0.
- R6: pcSrc is 1 only when the opcode is 000100 and aluZero is 1; otherwise it is 0.
- R7: Any opcode other than 000000, 100011, 101011 and 000100 raises illegalInsn=1 and drives every other output to 0.
- R8: Opcode 000000 with a function code outside the five listed in R2 raises illegalInsn=1 and drives every other output to 0.
- R9: For every supported instruction illegalInsn is 0, and aluZero has no effect on any output except pcSrc.
- R10: memRead and memWrite are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 6 | Primary opcode field of the instruction |
| funct | input | 6 | Function field, used when opcode is 000000 |
| aluZero | input | 1 | Zero result flag from the ALU |
| regDst | output | 1 | 1: write destination comes from the rd field |
| regWrite | output | 1 | Register file write enable |
| aluSrc | output | 1 | 1: second ALU operand is the sign-extended immediate |
| aluOp | output | 3 | ALU operation code |
| memWrite | output | 1 | Data memory write strobe |
| memRead | output | 1 | Data memory read strobe |
| memToReg | output | 1 | 1: write-back value comes from memory |
| pcSrc | output | 1 | 1: next PC is the branch target |
| illegalInsn | output | 1 | Opcode or function code not supported |

## Verification
Each register operation is applied with aluZero at both values. This separates the function-to-ALU mapping from the branch path and shows the zero flag is ignored there. Load, store and branch are each applied on their own, and the branch is tried once with zero low and once with zero high, which isolates pcSrc. Illegal opcodes and illegal function codes are probed with hand-picked values next to legal ones. A final sweep over all 64 opcodes with both zero values confirms that only the four decoded opcodes ever produce a strobe.

// File: rtl/insn_ctrl_pkg.sv
package insn_ctrl_pkg;
  parameter int OP_W  = 6;
  parameter int FN_W  = 6;
  parameter int ALU_W = 3;
  parameter int N_RFUNC = 5;

  localparam logic [OP_W-1:0] OPC_RTYPE  = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'b101011;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'b000100;

  localparam logic [ALU_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALU_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALU_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALU_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALU_W-1:0] ALU_SLT = 3'b111;

  typedef enum logic [2:0] {
    CL_RTYPE,
    CL_LOAD,
    CL_STORE,
    CL_BRANCH,
    CL_BAD
  } insnClass_e;

  typedef struct packed {
    logic regDst;
    logic regWrite;
    logic aluSrc;
    logic memWrite;
    logic memRead;
    logic memToReg;
    logic branch;
  } ctrlStrobes_t;
endpackage

// File: rtl/insn_class_decode.sv
module insn_class_decode
  import insn_ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output insnClass_e      cls
);
  always_comb begin
    unique case (opcode)
      OPC_RTYPE:  cls = CL_RTYPE;
      OPC_LOAD:   cls = CL_LOAD;
      OPC_STORE:  cls = CL_STORE;
      OPC_BRANCH: cls = CL_BRANCH;
      default:    cls = CL_BAD;
    endcase
  end
endmodule

// File: rtl/alu_sel.sv
module alu_sel
  import insn_ctrl_pkg::*;
(
  input  insnClass_e       cls,
  input  logic [FN_W-1:0]  funct,
  output logic [ALU_W-1:0] aluOp,
  output logic             funcBad
);
  localparam logic [FN_W-1:0]  FUNC_CODE [N_RFUNC] =
    '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
  localparam logic [ALU_W-1:0] FUNC_ALU  [N_RFUNC] =
    '{ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT};

  logic [N_RFUNC-1:0] hit;

  genvar gi;
  generate
    for (gi = 0; gi < N_RFUNC; gi++) begin : g_match
      assign hit[gi] = (funct == FUNC_CODE[gi]);
    end
  endgenerate

  logic [ALU_W-1:0] rOp;
  always_comb begin
    rOp = '0;
    for (int i = 0; i < N_RFUNC; i++) begin
      if (hit[i]) rOp = rOp | FUNC_ALU[i];
    end
  end

  always_comb begin
    funcBad = (cls == CL_RTYPE) && (hit == '0);
    unique case (cls)
      CL_RTYPE:           aluOp = rOp;
      CL_LOAD, CL_STORE:  aluOp = ALU_ADD;
      CL_BRANCH:          aluOp = ALU_SUB;
      default:            aluOp = '0;
    endcase
  end

  // R2
  always_comb begin
    func_unique_chk: assert ($onehot0(hit));
  end
endmodule

// File: rtl/main_ctrl.sv
module main_ctrl
  import insn_ctrl_pkg::*;
(
  input  insnClass_e   cls,
  input  logic         funcBad,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    unique case (cls)
      CL_RTYPE: begin
        if (!funcBad) begin
          strobes.regDst   = 1'b1;
          strobes.regWrite = 1'b1;
        end
      end
      CL_LOAD: begin
        strobes.regWrite = 1'b1;
        strobes.aluSrc   = 1'b1;
        strobes.memRead  = 1'b1;
        strobes.memToReg = 1'b1;
      end
      CL_STORE: begin
        strobes.aluSrc   = 1'b1;
        strobes.memWrite = 1'b1;
      end
      CL_BRANCH: strobes.branch = 1'b1;
      default:   strobes = '0;
    endcase
  end

  // R10
  always_comb begin
    mem_excl_chk: assert (!(strobes.memRead && strobes.memWrite));
  end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve (
  input  logic branch,
  input  logic aluZero,
  output logic pcSrc
);
  always_comb pcSrc = branch & aluZero;
endmodule

// File: rtl/insn_ctrl_decoder.sv
module insn_ctrl_decoder
  import insn_ctrl_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       aluZero,
  output logic       regDst,
  output logic       regWrite,
  output logic       aluSrc,
  output logic [2:0] aluOp,
  output logic       memWrite,
  output logic       memRead,
  output logic       memToReg,
  output logic       pcSrc,
  output logic       illegalInsn
);
  insnClass_e   cls;
  logic         funcBad;
  ctrlStrobes_t strobes;

  insn_class_decode u_cls (.opcode(opcode), .cls(cls));
  alu_sel u_alu (.cls(cls), .funct(funct), .aluOp(aluOp), .funcBad(funcBad));
  main_ctrl u_ctrl (.cls(cls), .funcBad(funcBad), .strobes(strobes));
  branch_resolve u_br (.branch(strobes.branch), .aluZero(aluZero), .pcSrc(pcSrc));

  assign regDst      = strobes.regDst;
  assign regWrite    = strobes.regWrite;
  assign aluSrc      = strobes.aluSrc;
  assign memWrite    = strobes.memWrite;
  assign memRead     = strobes.memRead;
  assign memToReg    = strobes.memToReg;
  assign illegalInsn = (cls == CL_BAD) || funcBad;

  always_comb begin
    // R7 R8
    illegal_quiet_chk: assert (!illegalInsn ||
      !(regWrite || memWrite || memRead || pcSrc || aluOp != 3'b000));
    // R6
    pcsrc_sub_chk: assert (!pcSrc || (aluOp == ALU_SUB && !regWrite && !aluSrc));
    // R3 R4
    mem_addr_chk: assert (!(memRead || memWrite) || (aluSrc && aluOp == ALU_ADD));
    // R1
    regdst_chk: assert (!regDst || (regWrite && !aluSrc));
  end
endmodule

// File: tb/insn_ctrl_decoder_tb_top.sv
module insn_ctrl_decoder_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [5:0] opcode = '0, funct = '0;
  logic       aluZero = 1'b0;
  logic regDst, regWrite, aluSrc, memWrite, memRead, memToReg, pcSrc, illegalInsn;
  logic [2:0] aluOp;

  int nChecks = 0, nFails = 0;

  insn_ctrl_decoder dut_i (
    .opcode(opcode), .funct(funct), .aluZero(aluZero),
    .regDst(regDst), .regWrite(regWrite), .aluSrc(aluSrc), .aluOp(aluOp),
    .memWrite(memWrite), .memRead(memRead), .memToReg(memToReg),
    .pcSrc(pcSrc), .illegalInsn(illegalInsn));

  // {regDst,regWrite,aluSrc,aluOp,memWrite,memRead,memToReg,pcSrc,illegal}
  function automatic logic [10:0] pack(logic d, logic w, logic s, logic [2:0] op,
      logic mw, logic mr, logic m2r, logic pc, logic ill);
    return {d, w, s, op, mw, mr, m2r, pc, ill};
  endfunction

  function automatic logic [10:0] expOf(logic [5:0] op, logic [5:0] fn, logic z);
    case (op)
      6'b000000: case (fn)
        6'b100000: return pack(1,1,0,3'b010,0,0,0,0,0);
        6'b100010: return pack(1,1,0,3'b110,0,0,0,0,0);
        6'b100100: return pack(1,1,0,3'b000,0,0,0,0,0);
        6'b100101: return pack(1,1,0,3'b001,0,0,0,0,0);
        6'b101010: return pack(1,1,0,3'b111,0,0,0,0,0);
        default:   return pack(0,0,0,3'b000,0,0,0,0,1);
      endcase
      6'b100011: return pack(0,1,1,3'b010,0,1,1,0,0);
      6'b101011: return pack(0,0,1,3'b010,1,0,0,0,0);
      6'b000100: return pack(0,0,0,3'b110,0,0,0,z,0);
      default:   return pack(0,0,0,3'b000,0,0,0,0,1);
    endcase
  endfunction

  task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z,
                       input logic [10:0] exp, input string req);
    logic [10:0] act;
    @(negedge clk);
    opcode = op; funct = fn; aluZero = z;
    #2;
    act = {regDst, regWrite, aluSrc, aluOp, memWrite, memRead, memToReg, pcSrc, illegalInsn};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s op=%b fn=%b z=%b actual=%b expected=%b", req, op, fn, z, act, exp);
    end
  endtask

  task automatic tIdle();  // all-zero inputs: add with func 000000 is illegal (R8)
    apply(6'b000000, 6'b000000, 0, pack(0,0,0,3'b000,0,0,0,0,1), "R8 idle");
  endtask

  task automatic tRtype();  // R1 R2 R9
    logic [5:0] fns [5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    for (int i = 0; i < 5; i++)
      for (int z = 0; z < 2; z++)
        apply(6'b000000, fns[i], z[0], expOf(6'b000000, fns[i], z[0]), "R1/R2 rtype");
  endtask

  task automatic tLoad();  // R3
    apply(6'b100011, 6'b101010, 1, pack(0,1,1,3'b010,0,1,1,0,0), "R3 load");
  endtask

  task automatic tStore();  // R4 R10
    apply(6'b101011, 6'b100000, 0, pack(0,0,1,3'b010,1,0,0,0,0), "R4 store");
  endtask

  task automatic tBranch();  // R5 R6
    apply(6'b000100, 6'b000000, 0, pack(0,0,0,3'b110,0,0,0,0,0), "R5 beq not taken");
    apply(6'b000100, 6'b100000, 1, pack(0,0,0,3'b110,0,0,0,1,0), "R6 beq taken");
  endtask

  task automatic tBadOp();  // R7
    logic [5:0] ops [4] = '{6'b000010, 6'b111111, 6'b001000, 6'b100001};
    foreach (ops[i])
      apply(ops[i], 6'b100000, 1, pack(0,0,0,3'b000,0,0,0,0,1), "R7 bad opcode");
  endtask

  task automatic tBadFunc();  // R8
    logic [5:0] fns [4] = '{6'b100001, 6'b111111, 6'b000100, 6'b101011};
    foreach (fns[i])
      apply(6'b000000, fns[i], 1, pack(0,0,0,3'b000,0,0,0,0,1), "R8 bad func");
  endtask

  task automatic tSweep();  // R6 R7 R9
    for (int op = 0; op < 64; op++)
      for (int z = 0; z < 2; z++)
        apply(op[5:0], 6'b100100, z[0], expOf(op[5:0], 6'b100100, z[0]), "R9 sweep");
  endtask

  initial begin
    tIdle();
    tRtype();
    tLoad();
    tStore();
    tBranch();
    tBadOp();
    tBadFunc();
    tSweep();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule